// File: doc/BRIEF.md
# GPIO bank with edge capture

A bank of up to 32 general-purpose pins behind a small word-addressed register port. Each pin has a direction bit and an output latch. Software changes the latch through two write-only ports, one that sets bits and one that clears them, so no read-modify-write is needed. All pin inputs pass through a two-flop synchroniser. Software reads the synchronised levels from a read-only register, whatever each pin's direction.

Each pin can arm rising-edge detection, falling-edge detection, or both. A detected edge sets a sticky status bit. Software clears that bit by writing a one to it. The OR of all status bits drives a registered interrupt line. A parameter limits the number of pins the bank implements. The unused upper bits then stay zero in every register and on every pad output.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every pin is an input (pad_oe_o all zero), the output latch pad_o is zero, both edge enables and the status register are zero, and irq_o is low.
- R2: Register 1 is the direction word. A 1 bit drives the matching pad_oe_o bit high (output) and a 0 bit makes the pin an input. The word reads back as written.
- R3: Writing register 2 (set port) drives high every pad_o bit whose write bit is 1 and leaves the other bits unchanged. Reads of registers 2, 3 and 7 return zero.
- R4: Writing register 3 (clear port) drives low every pad_o bit whose write bit is 1 and leaves the other bits unchanged.
- R5: Register 0 is read-only and returns the pad_i levels as they stood two clock edges earlier. This holds for inputs and outputs alike.
- R6: When register 4 (rising enable) has bit n set, a low-to-high change of synchronised pin n sets bit n of register 6 (status) on the third clock edge after pad_i changes.
- R7: When register 5 (falling enable) has bit n set, a high-to-low change of pin n sets status bit n with the same timing. An edge whose direction is not enabled leaves status unchanged.
- R8: With both enables set for a pin, either edge direction sets its status bit.
- R9: Writing register 6 clears each status bit written as 1 and leaves each bit written as 0 unchanged. Writing all ones clears every pending bit.
- R10: If an enabled edge on pin n and a clearing write to status bit n take effect on the same clock edge, the bit stays set.
- R11: irq_o is the registered OR of the status bits. It rises one cycle after a status bit sets and falls one cycle after the last bit clears.
- R12: With VALID_PINS below 32, bits at and above VALID_PINS read zero in every register, and pad_o and pad_oe_o stay zero there.
- R13: Writing a saved word to the set port and then its inverse to the clear port leaves pad_o equal to the saved word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register word select |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pad_i | input | 32 | Pin input levels (asynchronous) |
| pad_o | output | 32 | Output latch |
| pad_oe_o | output | 32 | Pad output enable, 1 = drive |
| irq_o | output | 1 | Combined edge interrupt |

## Verification
The bench loops each pad back: an output pin reads its own latch and an input pin reads an external stimulus word. This lets the level register separate the direction setting from the latch value. Edge tests cover rising-only, falling-only and both-enabled pins with single and mixed transitions. A transition in the wrong direction must leave status untouched, and a transition that lands on the same edge as a clearing write must survive. Status clears are tried with mixed one/zero masks and with an all-ones word. A second instance with fewer valid pins shows that the unused bits stay zero.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_LEVEL = 3'd0,
    REG_DIR   = 3'd1,
    REG_SET   = 3'd2,
    REG_CLR   = 3'd3,
    REG_RISE  = 3'd4,
    REG_FALL  = 3'd5,
    REG_STAT  = 3'd6,
    REG_NONE  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[i];
        stab_q <= meta_q;
      end
    end
    assign sync_o[i] = stab_q;
  end
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  pin_mask_i,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  latch_o,
  output logic [WIDTH-1:0]  rise_en_o,
  output logic [WIDTH-1:0]  fall_en_o
);
  logic [WIDTH-1:0] wd;
  assign wd = wdata_i & pin_mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o     <= '0;
      latch_o   <= '0;
      rise_en_o <= '0;
      fall_en_o <= '0;
    end else if (we_i) begin
      case (sel_i)
        REG_DIR:  dir_o     <= wd;
        REG_SET:  latch_o   <= latch_o | wd;
        REG_CLR:  latch_o   <= latch_o & ~wd;
        REG_RISE: rise_en_o <= wd;
        REG_FALL: fall_en_o <= wd;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_edge_capture.sv
module gpio_edge_capture #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_s_i,
  input  logic [WIDTH-1:0] rise_en_i,
  input  logic [WIDTH-1:0] fall_en_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] status_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] prev_q, hit;

  assign hit = (pin_s_i & ~prev_q & rise_en_i) | (~pin_s_i & prev_q & fall_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      prev_q   <= pin_s_i;
      // new edge overrides a simultaneous clear
      status_o <= (status_o & ~clr_i) | hit;
      irq_o    <= |status_o;
    end
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 32,
  parameter int unsigned VALID_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] pin_mask, pin_s, level, status_q, rise_q, fall_q, clr_word;
  reg_sel_e sel;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_mask
    assign pin_mask[i] = (i < VALID_PINS);
  end

  assign sel = reg_sel_e'(addr_i);

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_i),
    .sync_o  (pin_s)
  );
  assign level = pin_s & pin_mask;

  gpio_ctrl_regs #(.WIDTH(NUM_PINS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .sel_i      (sel),
    .wdata_i    (wdata_i),
    .pin_mask_i (pin_mask),
    .dir_o      (pad_oe_o),
    .latch_o    (pad_o),
    .rise_en_o  (rise_q),
    .fall_en_o  (fall_q)
  );

  assign clr_word = (we_i && sel == REG_STAT) ? (wdata_i & pin_mask) : '0;

  gpio_edge_capture #(.WIDTH(NUM_PINS)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_s_i   (level),
    .rise_en_i (rise_q),
    .fall_en_i (fall_q),
    .clr_i     (clr_word),
    .status_o  (status_q),
    .irq_o     (irq_o)
  );

  always_comb begin
    case (sel)
      REG_LEVEL: rdata_o = level;
      REG_DIR:   rdata_o = pad_oe_o;
      REG_RISE:  rdata_o = rise_q;
      REG_FALL:  rdata_o = fall_q;
      REG_STAT:  rdata_o = status_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2:0]          addr_i,
  input logic                we_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic [NUM_PINS-1:0] pad_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] status_q,
  input logic [NUM_PINS-1:0] rise_q,
  input logic [NUM_PINS-1:0] fall_q,
  input logic [NUM_PINS-1:0] pin_mask
);
  logic [NUM_PINS-1:0] clr_seen;
  assign clr_seen = (we_i && addr_i == 3'd6) ? wdata_i : '0;

  a_r11_irq_is_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 (irq_o == $past(|status_q)));

  a_r9_clear_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 ((($past(status_q) & ~status_q) & ~$past(clr_seen)) == '0));

  a_r6_set_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 (((status_q & ~$past(status_q)) & ~($past(rise_q) | $past(fall_q))) == '0));

  a_r3_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (addr_i == 3'd2 || addr_i == 3'd3)) |=> $stable(pad_o));

  a_r12_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_o | pad_oe_o | status_q) & ~pin_mask) == '0);
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .wdata_i  (wdata_i),
  .pad_o    (pad_o),
  .pad_oe_o (pad_oe_o),
  .irq_o    (irq_o),
  .status_q (status_q),
  .rise_q   (rise_q),
  .fall_q   (fall_q),
  .pin_mask (pin_mask)
);

// File: tb/sim_gpio_edge_bank.sv
module sim_gpio_edge_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] ext = '0;
  logic [31:0] rdata, pad_i, pad_o, pad_oe;
  logic [31:0] rdata1, pad_i1, pad_o1, pad_oe1;
  logic        irq, irq1;
  int total = 0, bad = 0, cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign pad_i  = (pad_oe & pad_o) | (~pad_oe & ext);
  assign pad_i1 = (pad_oe1 & pad_o1) | (~pad_oe1 & ext);

  gpio_edge_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_i(pad_i), .pad_o(pad_o), .pad_oe_o(pad_oe), .irq_o(irq));

  gpio_edge_bank #(.VALID_PINS(20)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata1), .pad_i(pad_i1), .pad_o(pad_o1), .pad_oe_o(pad_oe1), .irq_o(irq1));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(3'd4, '0); wr(3'd5, '0); wr(3'd6, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    check("R1 pad_o", pad_o, '0);
    check("R1 pad_oe", pad_oe, '0);
    check("R1 irq", {31'd0, irq}, '0);
    rd(3'd4, v); check("R1 rise", v, '0);
    rd(3'd5, v); check("R1 fall", v, '0);
    rd(3'd6, v); check("R1 status", v, '0);
  endtask

  task automatic t_dir_latch();
    logic [31:0] v;
    wr(3'd1, 32'h0000_FF0F);
    check("R2 oe", pad_oe, 32'h0000_FF0F);
    rd(3'd1, v); check("R2 readback", v, 32'h0000_FF0F);
    wr(3'd2, 32'h0000_0505);
    check("R3 set", pad_o, 32'h0000_0505);
    wr(3'd2, 32'h0000_3000);
    check("R3 set keeps others", pad_o, 32'h0000_3505);
    rd(3'd2, v); check("R3 set reads zero", v, '0);
    rd(3'd3, v); check("R3 clr reads zero", v, '0);
    rd(3'd7, v); check("R3 spare reads zero", v, '0);
    wr(3'd3, 32'h0000_1001);
    check("R4 clear", pad_o, 32'h0000_2504);
    wr(3'd2, 32'hA5A5_00F0);
    wr(3'd3, ~32'hA5A5_00F0);
    check("R13 restore", pad_o, 32'hA5A5_00F0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    // dir = 0000FF0F, latch = A5A500F0 -> driven bits 000000 00, ext elsewhere
    @(negedge clk);
    ext = 32'h1234_0080;
    @(negedge clk);
    rd(3'd0, v);
    check("R5 level not yet", v, 32'h0000_0000);
    @(negedge clk);
    rd(3'd0, v);
    check("R5 level mixed", v, 32'h1234_0080);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0000_0100);
    wait_n(2);
    rd(3'd0, v);
    check("R5 level output pin", v, 32'h1234_0180);
    wr(3'd1, '0);
    @(negedge clk); ext = '0;
    wait_n(3);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    clear_all();
    wr(3'd4, 32'h0000_0008);
    @(negedge clk); ext = 32'h0000_0018;
    wait_n(2);
    rd(3'd6, v); check("R6 status not yet", v, '0);
    @(negedge clk);
    rd(3'd6, v); check("R6 rise sets", v, 32'h0000_0008);
    check("R11 irq lags", {31'd0, irq}, '0);
    @(negedge clk);
    check("R11 irq high", {31'd0, irq}, 32'd1);
    @(negedge clk); ext = 32'h0000_0000;
    wait_n(4);
    rd(3'd6, v); check("R7 falling not enabled", v, 32'h0000_0008);
  endtask

  task automatic t_fall_both();
    logic [31:0] v;
    clear_all();
    @(negedge clk); ext = 32'h0000_0003;
    wait_n(4);
    wr(3'd5, 32'h0000_0001);
    wr(3'd4, 32'h0000_0002);
    wr(3'd5, 32'h0000_0003);
    @(negedge clk); ext = 32'h0000_0000;
    wait_n(3);
    rd(3'd6, v); check("R7 fall sets", v, 32'h0000_0003);
    wr(3'd6, 32'h0000_0002);
    rd(3'd6, v); check("R9 w1c partial", v, 32'h0000_0001);
    wr(3'd6, 32'h0000_0000);
    rd(3'd6, v); check("R9 zero write no effect", v, 32'h0000_0001);
    @(negedge clk); ext = 32'h0000_0002;
    wait_n(3);
    rd(3'd6, v); check("R8 both catches rise", v, 32'h0000_0003);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, v); check("R9 all ones clears", v, '0);
    @(negedge clk);
    check("R11 irq falls", {31'd0, irq}, '0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    // pin 1 high, rise+fall enabled, status clear
    @(negedge clk); ext = 32'h0000_0000;
    wait_n(3);
    rd(3'd6, v); check("R8 both catches fall", v, 32'h0000_0002);
    @(negedge clk); ext = 32'h0000_0002;
    @(negedge clk);
    @(negedge clk);
    addr = 3'd6; we = 1'b1; wdata = 32'h0000_0002;
    @(negedge clk);
    we = 1'b0;
    rd(3'd6, v); check("R10 edge beats clear", v, 32'h0000_0002);
    wr(3'd6, 32'h0000_0002);
    rd(3'd6, v); check("R10 later clear works", v, '0);
  endtask

  task automatic t_narrow();
    logic [31:0] v;
    clear_all();
    wr(3'd1, 32'hFFFF_FFFF);
    addr = 3'd1; #1;
    check("R12 dir masked", rdata1, 32'h000F_FFFF);
    check("R12 oe masked", pad_oe1, 32'h000F_FFFF);
    wr(3'd2, 32'hFFFF_FFFF);
    check("R12 latch masked", pad_o1, 32'h000F_FFFF);
    wait_n(2);
    addr = 3'd0; #1;
    check("R12 level masked", rdata1, 32'h000F_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd1, '0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog got=%0d exp=finish", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dir_latch();
    t_level();
    t_rise();
    t_fall_both();
    t_collide();
    t_narrow();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule